// File: doc/BRIEF.md
# Transmit checksum offload inserter

This block sits in a transmit path ahead of the MAC. For each outgoing frame it first takes a five-word control header on a 32-bit side channel, then the frame itself as a byte stream with an end marker on the final byte. While the frame bytes arrive they are stored in an internal frame buffer. In parallel, a running 16-bit ones-complement sum is kept over the bytes from a per-frame start offset onward. When the final byte has been stored, the block checks whether the frame must be dropped. If it is kept, the frame is replayed on the output stream. If the header asked for insertion, the inverted folded checksum replaces two bytes at a per-frame write offset as they go out.

A 32-bit transmit control word sets the drop rules. It holds a transmit-enable bit, a jumbo-allow bit, a VLAN-allow bit and a self-clearing reset bit. Each frame that is sent adds its length to a 64-bit byte counter and raises a sticky transmit-done flag. The header must be delivered before the frame data it belongs to. Header fields stay in force until a new header overwrites them.

Top module: `tcs_offload_top`

## Requirements
- R1: Header words are numbered from 0 after each word carrying `hdr_last`. Word 0 bit 0 enables insertion. Word 1 bits 31:16 give the start offset and bits 15:0 the write offset. Word 2 bits 15:0 give the seed. Words 3 and 4 (and any later word) are ignored. A newer header replaces the older one.
- R2: With insertion disabled, the output frame is byte for byte the input frame, and `out_last` marks its final byte.
- R3: The inserted value is the bitwise inverse of the 16-bit end-around-carry sum of the seed and of the 16-bit words formed from the bytes at offsets start..len-1. In each word, the byte at an even distance from the start is the high byte, and an odd final byte gets a zero low byte.
- R4: With insertion enabled, output byte `wo` carries checksum bits 15:8 and byte `wo+1` carries bits 7:0. A position at or past the frame end is not emitted. All other bytes are unchanged.
- R5: A start offset at or beyond the frame length gives the inverse of the seed.
- R6: While `tx_ctrl` bit 28 is 0, input bytes are still accepted (`in_ready` high) but are discarded. Nothing is emitted and the counter does not move.
- R7: A frame longer than `BUF_BYTES` (default 2048) is discarded whole, including all of its bytes up to `in_last`. A frame of exactly `BUF_BYTES` is sent, and the next frame is handled normally.
- R8: When `tx_ctrl` bits 30 and 27 are both 0, frames of 1519 to 1522 bytes are dropped. Frames of 1518 and 1523 bytes are sent. If either bit is 1, those lengths are sent.
- R9: Writing `cfg_wdata` with bit 31 set loads `tx_ctrl` with 0x5800_0000 (bits 30, 28, 27 set) and discards any partly received frame. Reset gives the same `tx_ctrl` value. A write with bit 31 clear stores the word as given.
- R10: On the output handshake of the final byte, `tx_byte_count` (reset 0) grows by the frame length and `tx_done` is set one cycle later. `tx_done_clr` clears `tx_done`; a set in the same cycle wins.
- R11: While a frame is being emitted, `in_ready` and `hdr_ready` are low. With `out_ready` low, `out_valid`, `out_data` and `out_last` hold.
- R12: `out_valid` rises in the cycle after the final input byte of a kept frame is accepted. Afterwards one byte leaves per cycle while `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the transmit control word |
| cfg_wdata | input | 32 | Transmit control write data |
| tx_ctrl | output | 32 | Current transmit control word |
| hdr_valid | input | 1 | Control header word valid |
| hdr_ready | output | 1 | Control header word accepted |
| hdr_data | input | 32 | Control header word |
| hdr_last | input | 1 | Final header word |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of the frame |
| tx_byte_count | output | 64 | Total bytes of sent frames |
| tx_done | output | 1 | Sticky frame-sent flag |
| tx_done_clr | input | 1 | Clears `tx_done` |

## Verification
A wrong running sum or a misplaced start offset shows in the two inserted bytes of the same frame, so sweeping start offset, odd and even lengths and write position pins it to one frame. A write pointer that is not reset after a drop, an overflow or a control reset pushes stale bytes to the front of the next sent frame. That appears at output byte 0 in the first cycle of emission. A wrong drop decision shows as a missing or extra frame, and `tx_byte_count` exposes it on the cycle after the final output handshake.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int unsigned CTRL_W      = 32;
   localparam int unsigned HDR_W       = 32;
   localparam int unsigned OFF_W       = 16;
   localparam int unsigned BIT_VLAN_OK = 27;
   localparam int unsigned BIT_TX_EN   = 28;
   localparam int unsigned BIT_JUMBO   = 30;
   localparam int unsigned BIT_RESET   = 31;
   localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 32'h5800_0000;

   typedef enum logic [0:0] {
      ST_COLLECT = 1'b0,
      ST_EMIT    = 1'b1
   } tcs_state_e;

   typedef struct packed {
      logic             ins_en;
      logic [OFF_W-1:0] start_off;
      logic [OFF_W-1:0] wr_off;
      logic [OFF_W-1:0] seed;
   } tcs_hdr_t;

   // end-around-carry reduction of a 32-bit partial sum to 16 bits
   function automatic logic [15:0] ones_fold(input logic [31:0] v);
      logic [31:0] t;
      t = v;
      for (int i = 0; i < 3; i++) begin
         t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
      end
      return t[15:0];
   endfunction

endpackage

// File: rtl/tcs_ctrl_reg.sv
module tcs_ctrl_reg
   import tcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              soft_rst
);

   assign soft_rst = cfg_wr & cfg_wdata[BIT_RESET];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_DEFAULT;
      end else if (cfg_wr) begin
         ctrl_q <= cfg_wdata[BIT_RESET] ? CTRL_DEFAULT : cfg_wdata;
      end
   end

   // R9
   ctrl_reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[BIT_RESET]) |=> (ctrl_q == CTRL_DEFAULT));

   // R9
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/tcs_hdr_capture.sv
module tcs_hdr_capture
   import tcs_pkg::*;
#(
   parameter int unsigned HDR_WORDS = 5
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_fire,
   input  logic [HDR_W-1:0] hdr_data,
   input  logic             hdr_last,
   output tcs_hdr_t         hdr_q
);

   localparam int unsigned CNT_W = $clog2(HDR_WORDS + 1);

   generate
      if (HDR_WORDS < 3) begin : g_bad_words
         $error("tcs_hdr_capture: HDR_WORDS must cover the three used words");
      end
   endgenerate

   logic [CNT_W-1:0] word_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_idx_q <= '0;
      end else if (hdr_fire) begin
         if (hdr_last) begin
            word_idx_q <= '0;
         end else if (word_idx_q != CNT_W'(HDR_WORDS)) begin
            word_idx_q <= word_idx_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
      end else if (hdr_fire) begin
         if (word_idx_q == CNT_W'(0)) begin
            hdr_q.ins_en <= hdr_data[0];
         end else if (word_idx_q == CNT_W'(1)) begin
            hdr_q.start_off <= hdr_data[31:16];
            hdr_q.wr_off    <= hdr_data[15:0];
         end else if (word_idx_q == CNT_W'(2)) begin
            hdr_q.seed <= hdr_data[15:0];
         end
      end
   end

   // R1
   hdr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_fire && hdr_last) |=> (word_idx_q == CNT_W'(0)));

   // R1
   hdr_tail_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_idx_q > CNT_W'(2)) |=> $stable(hdr_q));

endmodule

// File: rtl/tcs_sum_acc.sv
module tcs_sum_acc
   import tcs_pkg::*;
#(
   parameter int unsigned POS_W = 12,
   parameter int unsigned SUM_W = 32
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             acc_en,
   input  logic [7:0]       byte_in,
   input  logic [POS_W-1:0] pos,
   input  logic [OFF_W-1:0] start_off,
   output logic [SUM_W-1:0] sum_nxt
);

   generate
      if (SUM_W > 32 || SUM_W < POS_W + 16) begin : g_bad_sum
         $error("tcs_sum_acc: SUM_W must hold a full buffer and fit the fold");
      end
      if (POS_W > OFF_W) begin : g_bad_pos
         $error("tcs_sum_acc: POS_W wider than the offset fields");
      end
   endgenerate

   logic [SUM_W-1:0] sum_q;
   logic [OFF_W:0]   pos_x;
   logic [OFF_W:0]   rel;
   logic             in_range;
   logic [15:0]      term;

   always_comb begin
      pos_x    = (OFF_W+1)'(pos);
      in_range = pos_x >= {1'b0, start_off};
      rel      = pos_x - {1'b0, start_off};
      if (!in_range) begin
         term = 16'h0;
      end else if (rel[0]) begin
         term = {8'h00, byte_in};
      end else begin
         term = {byte_in, 8'h00};
      end
      sum_nxt = sum_q + SUM_W'(term);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (clr) begin
         sum_q <= '0;
      end else if (acc_en) begin
         sum_q <= sum_nxt;
      end
   end

   // R3
   sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum_q == '0));

   // R3
   sum_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !clr) |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/tcs_frame_buf.sv
module tcs_frame_buf #(
   parameter int unsigned DEPTH = 2048,
   parameter int unsigned DW    = 8
)
(
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [DW-1:0]            rd_data
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tcs_frame_buf: DEPTH must be at least 2");
      end
      if (POW2) begin : g_direct
         assign rd_data = mem[rd_addr];
      end else begin : g_guarded
         assign rd_data = (32'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
      end
   endgenerate

endmodule

// File: rtl/tcs_offload_top.sv
module tcs_offload_top
   import tcs_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 2048,
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned STD_MAX   = 1518,
   parameter int unsigned TAG_MAX   = 1522
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] tx_ctrl,
   input  logic              hdr_valid,
   output logic              hdr_ready,
   input  logic [HDR_W-1:0]  hdr_data,
   input  logic              hdr_last,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic [CNT_W-1:0]  tx_byte_count,
   output logic              tx_done,
   input  logic              tx_done_clr
);

   localparam int unsigned POS_W = $clog2(BUF_BYTES + 1);
   localparam int unsigned AW    = $clog2(BUF_BYTES);
   localparam int unsigned SUM_W = 32;

   generate
      if (POS_W > OFF_W) begin : g_bad_buf
         $error("tcs_offload_top: BUF_BYTES exceeds the offset range");
      end
      if (CNT_W < POS_W) begin : g_bad_cnt
         $error("tcs_offload_top: CNT_W narrower than a frame length");
      end
      if (TAG_MAX < STD_MAX) begin : g_bad_sizes
         $error("tcs_offload_top: TAG_MAX below STD_MAX");
      end
   endgenerate

   tcs_state_e       st_q;
   tcs_hdr_t         hdr;
   logic             soft_rst;
   logic [POS_W-1:0] wr_pos_q, rd_pos_q, frm_len_q, new_len;
   logic             skip_q;
   logic [15:0]      csum_q;
   logic             ins_q;
   logic [OFF_W-1:0] wo_q;
   logic [SUM_W-1:0] sum_nxt;
   logic [7:0]       buf_rd;
   logic             in_fire, out_fire, tx_en, room;
   logic             take, ovf_hit, frame_end, size_bad, launch, emit_end;
   logic [OFF_W:0]   rd_x, wo_x;

   tcs_ctrl_reg u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .ctrl_q    (tx_ctrl),
      .soft_rst  (soft_rst)
   );

   tcs_hdr_capture #(.HDR_WORDS(5)) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .hdr_fire (hdr_valid & hdr_ready),
      .hdr_data (hdr_data),
      .hdr_last (hdr_last),
      .hdr_q    (hdr)
   );

   // ---------------- ingest and drop decisions ----------------
   assign in_ready  = (st_q == ST_COLLECT);
   assign hdr_ready = (st_q == ST_COLLECT);
   assign in_fire   = in_valid & in_ready;
   assign tx_en     = tx_ctrl[BIT_TX_EN];
   assign room      = (wr_pos_q != POS_W'(BUF_BYTES));
   assign take      = in_fire & tx_en & ~skip_q & room;
   assign ovf_hit   = in_fire & tx_en & ~skip_q & ~room;
   assign frame_end = take & in_last;
   assign new_len   = wr_pos_q + POS_W'(1);
   assign size_bad  = ~tx_ctrl[BIT_JUMBO] & ~tx_ctrl[BIT_VLAN_OK]
                      & (new_len > POS_W'(STD_MAX)) & (new_len <= POS_W'(TAG_MAX));
   assign launch    = frame_end & ~size_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pos_q <= '0;
         skip_q   <= 1'b0;
      end else if (soft_rst) begin
         wr_pos_q <= '0;
         skip_q   <= 1'b0;
      end else if (frame_end || ovf_hit) begin
         wr_pos_q <= '0;
         skip_q   <= ovf_hit & ~in_last;
      end else if (take) begin
         wr_pos_q <= new_len;
      end else if (in_fire && skip_q && in_last) begin
         skip_q <= 1'b0;
      end
   end

   tcs_sum_acc #(.POS_W(POS_W), .SUM_W(SUM_W)) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst | frame_end | ovf_hit),
      .acc_en    (take),
      .byte_in   (in_data),
      .pos       (wr_pos_q),
      .start_off (hdr.start_off),
      .sum_nxt   (sum_nxt)
   );

   tcs_frame_buf #(.DEPTH(BUF_BYTES), .DW(8)) u_buf (
      .clk     (clk),
      .wr_en   (take),
      .wr_addr (wr_pos_q[AW-1:0]),
      .wr_data (in_data),
      .rd_addr (rd_pos_q[AW-1:0]),
      .rd_data (buf_rd)
   );

   // ---------------- emission ----------------
   assign out_valid = (st_q == ST_EMIT);
   assign out_fire  = out_valid & out_ready;
   assign out_last  = out_valid & (rd_pos_q == frm_len_q - POS_W'(1));
   assign emit_end  = out_fire & out_last;
   assign rd_x      = (OFF_W+1)'(rd_pos_q);
   assign wo_x      = {1'b0, wo_q};

   always_comb begin
      if (ins_q && rd_x == wo_x) begin
         out_data = csum_q[15:8];
      end else if (ins_q && rd_x == wo_x + (OFF_W+1)'(1)) begin
         out_data = csum_q[7:0];
      end else begin
         out_data = buf_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_COLLECT;
         rd_pos_q  <= '0;
         frm_len_q <= '0;
         csum_q    <= '0;
         ins_q     <= 1'b0;
         wo_q      <= '0;
      end else if (st_q == ST_COLLECT) begin
         if (launch) begin
            st_q      <= ST_EMIT;
            rd_pos_q  <= '0;
            frm_len_q <= new_len;
            csum_q    <= ~ones_fold(32'(sum_nxt) + {16'h0, hdr.seed});
            ins_q     <= hdr.ins_en;
            wo_q      <= hdr.wr_off;
         end
      end else if (out_fire) begin
         if (out_last) begin
            st_q <= ST_COLLECT;
         end else begin
            rd_pos_q <= rd_pos_q + POS_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte_count <= '0;
         tx_done       <= 1'b0;
      end else begin
         if (emit_end) begin
            tx_byte_count <= tx_byte_count + CNT_W'(frm_len_q);
         end
         if (emit_end) begin
            tx_done <= 1'b1;
         end else if (tx_done_clr) begin
            tx_done <= 1'b0;
         end
      end
   end

   // R10
   byte_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emit_end |=> (tx_byte_count == $past(tx_byte_count) + CNT_W'($past(frm_len_q))));

   // R10
   byte_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !emit_end |=> $stable(tx_byte_count));

   // R10
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emit_end |=> tx_done);

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R7
   wr_pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pos_q <= POS_W'(BUF_BYTES));

   // R12
   emit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (out_valid && rd_pos_q == '0));

endmodule

// File: tb/tcs_offload_top_tb_top.sv
module tcs_offload_top_tb_top;

   localparam int BUF = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] tx_ctrl;
   logic        hdr_valid = 1'b0;
   logic        hdr_ready;
   logic [31:0] hdr_data = '0;
   logic        hdr_last = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        out_last;
   logic [63:0] tx_byte_count;
   logic        tx_done;
   logic        tx_done_clr = 1'b0;

   always #2 clk = ~clk;

   tcs_offload_top #(.BUF_BYTES(BUF)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .tx_ctrl(tx_ctrl), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
      .hdr_data(hdr_data), .hdr_last(hdr_last), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .tx_byte_count(tx_byte_count), .tx_done(tx_done),
      .tx_done_clr(tx_done_clr)
   );

   int          n_chk = 0;
   int          n_err = 0;
   bit          finished = 0;
   logic [63:0] exp_bytes = 0;
   logic [7:0]  fr [0:4095];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int len, input int salt);
      for (int i = 0; i < len; i++) fr[i] = 8'((i * 13 + salt * 7 + 3) & 255);
   endtask

   function automatic logic [15:0] model_csum(input int len, input int st, input logic [15:0] seed);
      longint acc;
      acc = longint'(seed);
      for (int i = st; i < len; i++) begin
         if (((i - st) % 2) == 0) acc += longint'(fr[i]) << 8;
         else acc += longint'(fr[i]);
      end
      while ((acc >> 16) != 0) acc = (acc & 64'hffff) + (acc >> 16);
      return ~acc[15:0];
   endfunction

   task automatic cfg_write(input logic [31:0] v);
      @(posedge clk); #1;
      cfg_wr = 1'b1; cfg_wdata = v;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic send_hdr(input bit ins, input logic [15:0] st, input logic [15:0] wo,
                           input logic [15:0] seed, input logic [31:0] junk);
      logic [31:0] w [5];
      w[0] = {31'h0, ins}; w[1] = {st, wo}; w[2] = {junk[15:0], seed};
      w[3] = junk; w[4] = ~junk;
      @(posedge clk); #1;
      for (int i = 0; i < 5; i++) begin
         hdr_valid = 1'b1; hdr_data = w[i]; hdr_last = (i == 4);
         @(posedge clk); #1;
      end
      hdr_valid = 1'b0; hdr_last = 1'b0;
   endtask

   task automatic send_bytes(input int len, input bit with_last);
      @(posedge clk); #1;
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1; in_data = fr[i % 4096]; in_last = with_last && (i == len - 1);
         @(posedge clk); #1;
      end
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   // receives one frame; first output byte is expected at the first negedge
   task automatic recv(input int len, input bit ins, input int wo, input logic [15:0] cs,
                       input int stall_at, input string req);
      bit ok = 1;
      logic [7:0] act_b = 0, exp_b = 0;
      for (int i = 0; i < len; i++) begin
         logic [7:0] e;
         @(negedge clk);
         if (ins && i == wo) e = cs[15:8];
         else if (ins && i == wo + 1) e = cs[7:0];
         else e = fr[i];
         if (ok && (!out_valid || out_data != e || out_last != (i == len - 1))) begin
            ok = 0; act_b = out_data; exp_b = e;
         end
         if (i == stall_at) begin
            out_ready = 1'b0;
            for (int k = 0; k < 2; k++) begin
               @(negedge clk);
               if (ok && (!out_valid || out_data != e)) begin
                  ok = 0; act_b = out_data; exp_b = e;
               end
               chk(!in_ready && !hdr_ready, "R11", "input blocked during emit",
                   {in_ready, hdr_ready}, 0);
            end
            out_ready = 1'b1;
         end
      end
      @(negedge clk);
      if (out_valid) ok = 0;
      chk(ok, req, $sformatf("frame len=%0d bytes", len), act_b, exp_b);
      exp_bytes += 64'(len);
      chk(tx_byte_count == exp_bytes, "R10", "byte count", tx_byte_count, exp_bytes);
   endtask

   task automatic expect_none(input int cycles, input string req);
      bit seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (out_valid) seen = 1;
      end
      chk(!seen && tx_byte_count == exp_bytes, req, "frame dropped", tx_byte_count, exp_bytes);
   endtask

   task automatic run_frame(input int len, input int salt, input bit ins, input int st,
                            input int wo, input logic [15:0] seed, input int stall_at,
                            input string req);
      logic [15:0] cs;
      fill(len, salt);
      cs = model_csum(len, st, seed);
      send_hdr(ins, 16'(st), 16'(wo), seed, 32'(salt * 977));
      send_bytes(len, 1'b1);
      recv(len, ins, wo, cs, stall_at, req);
   endtask

   initial begin
      #600000;
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9 reset value, R10 counter reset, R11 ready at rest
      chk(tx_ctrl == 32'h5800_0000, "R9", "reset ctrl", tx_ctrl, 32'h5800_0000);
      chk(tx_byte_count == 0 && !tx_done, "R10", "reset counter", tx_byte_count, 0);
      chk(!out_valid && in_ready && hdr_ready, "R11", "idle handshakes",
          {out_valid, in_ready, hdr_ready}, 3'b011);

      // R2 pass-through, several lengths
      run_frame(1, 1, 0, 0, 0, 0, -1, "R2");
      run_frame(2, 2, 0, 0, 0, 0, -1, "R2");
      run_frame(14, 3, 0, 0, 0, 0, -1, "R2");
      run_frame(64, 4, 0, 0, 0, 0, -1, "R2");
      chk(tx_done, "R10", "done set", tx_done, 1);
      @(posedge clk); #1 tx_done_clr = 1'b1;
      @(posedge clk); #1 tx_done_clr = 1'b0;
      @(negedge clk);
      chk(!tx_done, "R10", "done cleared", tx_done, 0);

      // R3 R4 sweep of start offset, length parity and write position
      for (int st = 0; st < 6; st++) begin
         for (int len = 14; len < 18; len++) begin
            int wos [4];
            wos[0] = 0; wos[1] = 2; wos[2] = len - 2; wos[3] = len - 1;
            for (int w = 0; w < 4; w++) begin
               run_frame(len, st * 11 + len + w, 1, st, wos[w],
                         16'((st * 4099 + len * 31 + w * 517) & 16'hffff), -1, "R3");
            end
         end
      end
      // R4 write offset past the end: frame unchanged
      run_frame(20, 90, 1, 0, 40, 16'h1234, -1, "R4");
      // R5 start beyond the frame
      run_frame(16, 91, 1, 20, 4, 16'hbeef, -1, "R5");
      run_frame(16, 92, 1, 16, 0, 16'h0000, -1, "R5");
      // R11 R12 backpressure inside a checksummed frame
      run_frame(30, 93, 1, 14, 24, 16'h00ff, 10, "R11");
      run_frame(30, 94, 1, 14, 10, 16'h8001, 11, "R12");

      // R1 a second header overrides, extra words ignored
      fill(18, 95);
      send_hdr(1, 16'd3, 16'd5, 16'h7777, 32'hffff_ffff);
      send_hdr(1, 16'd2, 16'd8, 16'h0102, 32'h5a5a_a5a5);
      send_bytes(18, 1'b1);
      recv(18, 1, 8, model_csum(18, 2, 16'h0102), -1, "R1");

      // R6 transmit disabled
      cfg_write(32'h4800_0000);
      chk(tx_ctrl == 32'h4800_0000, "R9", "plain ctrl write", tx_ctrl, 32'h4800_0000);
      fill(20, 96);
      send_hdr(0, 0, 0, 0, 0);
      send_bytes(20, 1'b1);
      expect_none(6, "R6");
      cfg_write(32'h5800_0000);
      run_frame(12, 97, 0, 0, 0, 0, -1, "R6");

      // R7 overflow
      fill(BUF + 2, 98);
      send_hdr(0, 0, 0, 0, 0);
      send_bytes(BUF + 1, 1'b1);
      expect_none(6, "R7");
      send_bytes(BUF + 2, 1'b1);
      expect_none(6, "R7");
      run_frame(10, 99, 0, 0, 0, 0, -1, "R7");
      run_frame(BUF, 100, 1, 100, 200, 16'h4242, -1, "R7");

      // R8 size rule
      cfg_write(32'h1000_0000);
      run_frame(1518, 101, 0, 0, 0, 0, -1, "R8");
      fill(1519, 102); send_hdr(0, 0, 0, 0, 0); send_bytes(1519, 1'b1);
      expect_none(6, "R8");
      fill(1522, 103); send_bytes(1522, 1'b1);
      expect_none(6, "R8");
      run_frame(1523, 104, 0, 0, 0, 0, -1, "R8");
      cfg_write(32'h1800_0000);
      run_frame(1520, 105, 0, 0, 0, 0, -1, "R8");
      cfg_write(32'h5000_0000);
      run_frame(1521, 106, 0, 0, 0, 0, -1, "R8");

      // R9 control reset drops a partial frame
      cfg_write(32'h0000_0000);
      cfg_write(32'h8000_0000);
      chk(tx_ctrl == 32'h5800_0000, "R9", "reset bit", tx_ctrl, 32'h5800_0000);
      fill(10, 107);
      send_hdr(0, 0, 0, 0, 0);
      send_bytes(10, 1'b0);
      cfg_write(32'h8000_0000);
      run_frame(8, 108, 0, 0, 0, 0, -1, "R9");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule